// File: doc/BRIEF.md
# Multicycle Five-Instruction Processor Core

This block is a small 32-bit processor core that spreads each instruction over several clock cycles. A hardwired state machine steps through fetch, decode, execute, memory and write-back. Intermediate results are kept in holding registers: an instruction register, two operand registers, an ALU result register and a load-data register. Each step only has to cover one short piece of logic, so the clock period is set by the slowest single step rather than by the slowest complete instruction.

The core runs five kinds of instruction: register-register add or subtract, OR with an immediate, word load, word store, and branch on equal. The 32-entry register file is inside the block. Instruction memory and data memory are outside it. Both are read combinationally within the current state and written on the clock edge. The program counter is brought out as a debug view.

Each instruction commits its program-counter update only on the edge that leaves its last state. A test harness can therefore time every instruction class by watching that output.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low on a rising edge, the core returns to the fetch state with PC = 0. After release, the first fetch reads address 0, and `dmem_we` stays low throughout reset.
- R2: Opcode 000000 (bits 31:26) is register-register. The function field in bits 5:0 selects the operation: 100011 subtracts rt from rs, and any other value adds them. The result goes to the register named in bits 15:11. PC advances by 4 four cycles after the fetch began.
- R3: Opcode 001101 ORs R[rs] (bits 25:21) with the zero-extended 16-bit immediate (bits 15:0) and writes the result to R[rt] (bits 20:16). PC advances by 4 after four cycles.
- R4: Opcode 100011 loads the word at R[rs] plus the sign-extended immediate into R[rt]. PC advances by 4 after five cycles.
- R5: Opcode 101011 writes R[rt] to data memory at R[rs] plus the sign-extended immediate. `dmem_we` is high for exactly one cycle, the fourth and last of the instruction, after which PC advances by 4.
- R6: Opcode 000100 compares R[rs] and R[rt] by subtraction. If they are equal, PC becomes PC plus the sign-extended immediate shifted left by two. Otherwise PC advances by 4. The instruction takes three cycles.
- R7: Register 0 reads as zero, and every write aimed at it is dropped.
- R8: PC holds its value in every state except the last state of an instruction. The fetch state is always followed by the decode state.
- R9: Any other opcode finishes in the decode state, two cycles in total. PC advances by 4, and no register and no memory word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | XLEN | Instruction fetch byte address (equals PC) |
| imem_rdata | input | XLEN | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | XLEN | Data byte address, taken from the ALU result register |
| dmem_wdata | output | XLEN | Store data, taken from operand register B |
| dmem_rdata | input | XLEN | Data word at `dmem_addr`, valid in the same cycle |
| dmem_we | output | 1 | Data write strobe; the word is written on the rising edge |
| pc_dbg | output | XLEN | Debug view of the program counter |

## Verification
The assertions assume that instruction and data reads return their word in the same cycle the address is presented. They also assume that reset is held for at least one rising edge before the first instruction is judged. The bench models both memories as small word arrays with combinational reads and edge-triggered writes. It holds `rst_n` low for three edges before each program and ends every program in a branch-to-self loop, so the core never fetches beyond the loaded words. Register contents are observed only by storing them back to data memory, together with the PC value at which each program settles.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
// Shared types for the multicycle core: controller states, ALU and operand
// selects, opcode/function encodings and the per-state control bundle.
package mc_pkg;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE,
        S_EX_R, S_EX_ORI, S_EX_LW, S_EX_SW, S_BR,
        S_WB_R, S_WB_ORI, S_MEM_LW, S_WB_LW, S_MEM_SW
    } state_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;
    typedef enum logic [1:0] {OPB_REG, OPB_ZX, OPB_SX}  opb_e;
    typedef enum logic [1:0] {PC_HOLD, PC_SEQ, PC_BR}   pcsel_e;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] FN_SUB   = 6'b100011;

    typedef struct packed {
        logic    ir_en;     // capture instruction word
        logic    ab_en;     // capture operands A and B
        logic    s_en;      // capture ALU result
        alu_op_e alu_op;
        opb_e    opb;       // second ALU operand source
        logic    m_en;      // capture load data
        logic    rf_we;
        logic    rf_dst_rd; // 1: destination rd, 0: rt
        logic    rf_from_m; // 1: write M, 0: write S
        logic    dm_we;
        pcsel_e  pc_sel;
    } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
// ALU of the multicycle core: add, subtract or bitwise OR of two operands.
// Assumes the operation select is always one of the three defined codes.
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    // Select the result of the requested operation.
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
// Register file: two combinational read ports, one write port on the rising
// edge. Entry 0 is a constant zero, so writes addressed to it are lost.
// Assumes a single writer per cycle; all live entries clear on reset.
module mc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    localparam int N = 1 << AW;

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_live
            // Hold or update one register entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (we && wa == AW'(i))
                    regs[i] <= wd;
            end
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
// Hardwired controller: from the present state, opcode, function field and
// branch-equal flag, produce the next state and the register-transfer
// enables. A transfer asserted here lands on the edge that leaves the state.
// Assumes the opcode is taken from the already captured instruction word.
module mc_ctrl
    import mc_pkg::*;
(
    input  state_e     state_q,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       br_eq,
    output state_e     state_d,
    output ctrl_t      ctl
);

    // Next-state and control-point decode for the present state.
    always_comb begin
        state_d       = S_FETCH;
        ctl.ir_en     = 1'b0;
        ctl.ab_en     = 1'b0;
        ctl.s_en      = 1'b0;
        ctl.alu_op    = ALU_ADD;
        ctl.opb       = OPB_REG;
        ctl.m_en      = 1'b0;
        ctl.rf_we     = 1'b0;
        ctl.rf_dst_rd = 1'b0;
        ctl.rf_from_m = 1'b0;
        ctl.dm_we     = 1'b0;
        ctl.pc_sel    = PC_HOLD;
        unique case (state_q)
            S_FETCH: begin
                ctl.ir_en = 1'b1;
                state_d   = S_DECODE;
            end
            S_DECODE: begin
                ctl.ab_en = 1'b1;
                unique case (opcode)
                    OP_RTYPE: state_d = S_EX_R;
                    OP_ORI:   state_d = S_EX_ORI;
                    OP_LW:    state_d = S_EX_LW;
                    OP_SW:    state_d = S_EX_SW;
                    OP_BEQ:   state_d = S_BR;
                    default: begin
                        ctl.pc_sel = PC_SEQ;
                        state_d    = S_FETCH;
                    end
                endcase
            end
            S_EX_R: begin
                ctl.s_en   = 1'b1;
                ctl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
                state_d    = S_WB_R;
            end
            S_EX_ORI: begin
                ctl.s_en   = 1'b1;
                ctl.alu_op = ALU_OR;
                ctl.opb    = OPB_ZX;
                state_d    = S_WB_ORI;
            end
            S_EX_LW: begin
                ctl.s_en = 1'b1;
                ctl.opb  = OPB_SX;
                state_d  = S_MEM_LW;
            end
            S_EX_SW: begin
                ctl.s_en = 1'b1;
                ctl.opb  = OPB_SX;
                state_d  = S_MEM_SW;
            end
            S_BR: begin
                ctl.pc_sel = br_eq ? PC_BR : PC_SEQ;
            end
            S_WB_R: begin
                ctl.rf_we     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
                ctl.pc_sel    = PC_SEQ;
            end
            S_WB_ORI: begin
                ctl.rf_we  = 1'b1;
                ctl.pc_sel = PC_SEQ;
            end
            S_MEM_LW: begin
                ctl.m_en = 1'b1;
                state_d  = S_WB_LW;
            end
            S_WB_LW: begin
                ctl.rf_we     = 1'b1;
                ctl.rf_from_m = 1'b1;
                ctl.pc_sel    = PC_SEQ;
            end
            S_MEM_SW: begin
                ctl.dm_we  = 1'b1;
                ctl.pc_sel = PC_SEQ;
            end
            default: state_d = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
// Multicycle core top: PC, holding registers IR/A/B/S/M, register file,
// ALU and controller. Memories are external with same-cycle read data and
// edge-triggered write. PC changes only in each instruction's last state.
module mc_core
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_we,
    output logic [XLEN-1:0] pc_dbg
);

    localparam int RAW  = 5;
    localparam int IMMW = 16;

    state_e          state_q, state_d;
    ctrl_t           ctl;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] ir_q, a_q, b_q, s_q, m_q;
    logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [XLEN-1:0] alu_b, alu_y;
    logic [XLEN-1:0] imm_zx, imm_sx;
    logic [RAW-1:0]  rf_wa;
    logic            br_eq;

    wire [5:0]      opcode = ir_q[31:26];
    wire [RAW-1:0]  f_rs   = ir_q[25:21];
    wire [RAW-1:0]  f_rt   = ir_q[20:16];
    wire [RAW-1:0]  f_rd   = ir_q[15:11];
    wire [IMMW-1:0] f_imm  = ir_q[15:0];
    wire [5:0]      funct  = ir_q[5:0];

    assign imm_zx = {{(XLEN-IMMW){1'b0}}, f_imm};
    assign imm_sx = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
    assign br_eq  = (a_q - b_q) == '0;

    mc_ctrl u_ctrl (
        .state_q (state_q),
        .opcode  (opcode),
        .funct   (funct),
        .br_eq   (br_eq),
        .state_d (state_d),
        .ctl     (ctl)
    );

    mc_regfile #(.W(XLEN), .AW(RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (ctl.rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    mc_alu #(.W(XLEN)) u_alu (
        .a  (a_q),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    // Pick the second ALU operand.
    always_comb begin
        unique case (ctl.opb)
            OPB_ZX:  alu_b = imm_zx;
            OPB_SX:  alu_b = imm_sx;
            default: alu_b = b_q;
        endcase
    end

    // Register-file write destination and data.
    assign rf_wa = ctl.rf_dst_rd ? f_rd : f_rt;
    assign rf_wd = ctl.rf_from_m ? m_q : s_q;

    // Next PC: hold, step by one word, or branch by a word offset.
    always_comb begin
        unique case (ctl.pc_sel)
            PC_SEQ:  pc_d = pc_q + XLEN'(4);
            PC_BR:   pc_d = pc_q + (imm_sx << 2);
            default: pc_d = pc_q;
        endcase
    end

    // Controller state and PC update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Holding registers, each loaded when its transfer is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            s_q  <= '0;
            m_q  <= '0;
        end else begin
            if (ctl.ir_en) ir_q <= imem_rdata;
            if (ctl.ab_en) begin
                a_q <= rf_rd1;
                b_q <= rf_rd2;
            end
            if (ctl.s_en)  s_q <= alu_y;
            if (ctl.m_en)  m_q <= dmem_rdata;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = s_q;
    assign dmem_wdata = b_q;
    assign dmem_we    = ctl.dm_we;
    assign pc_dbg     = pc_q;

endmodule

// File: rtl/mc_core_chk.sv
`timescale 1ns/1ps
// Temporal checks on the multicycle core, attached to every instance by bind.
// Assumes the core's synchronous active-low reset and same-cycle memory reads.
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input state_e          state_q,
    input logic [XLEN-1:0] pc_q,
    input logic            dmem_we,
    input logic            br_eq
);

    // R1: the first cycle after reset starts at fetch with PC zero.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pc_q == '0 && state_q == S_FETCH));

    // R8: fetch always leads to decode without touching PC.
    p_fetch_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH) |=> (state_q == S_DECODE && $stable(pc_q)));

    // R2: register-register write-back ends the instruction and steps PC.
    p_rtype_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WB_R) |=> (state_q == S_FETCH && pc_q == $past(pc_q) + XLEN'(4)));

    // R6: an unequal compare falls through to the next word.
    p_beq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BR && !br_eq) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R5: the store strobe is a single-cycle pulse at the end of a store.
    p_store_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (!dmem_we && state_q == S_FETCH));

    // R4: a load's address step is followed by the memory read step.
    p_load_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EX_LW) |=> (state_q == S_MEM_LW && $stable(pc_q)));

endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .pc_q    (pc_q),
    .dmem_we (dmem_we),
    .br_eq   (br_eq)
);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the multicycle core: one task per scenario, each
// loading a small program, running it and checking memory and PC.
module mc_core_tb_top;

    localparam int XLEN = 32;
    localparam logic [31:0] HALT = 32'h1000_0000; // branch-equal r0,r0,0

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] imem_addr, imem_rdata;
    logic [XLEN-1:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic            dmem_we;
    logic [XLEN-1:0] pc_dbg;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          wr_cnt = 0;
    int          n_chk  = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    mc_core #(.XLEN(XLEN)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .pc_dbg     (pc_dbg)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (rst_n && dmem_we) begin
            dmem[dmem_addr[7:2]] = dmem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd,
                                          input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op,
                                          input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = HALT;
            dmem[i] = 32'hA5A5_0000 + 32'(i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        wr_cnt = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R1: reset in the middle of a program brings PC back to zero.
    task automatic t_reset();
        clear_mem();
        imem[0] = enc_i(6'b001101, 5'd0, 5'd1, 16'h0004);
        imem[1] = enc_i(6'b101011, 5'd0, 5'd1, 16'h0000);
        do_reset();
        chk("R1 pc after reset", pc_dbg, 32'h0);
        run(6);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc during reset", pc_dbg, 32'h0);
        chk("R1 fetch address during reset", imem_addr, 32'h0);
        chk("R1 no write during reset", {31'b0, dmem_we}, 32'h0);
    endtask

    // R3: OR-immediate with zero extension.
    task automatic t_ori();
        clear_mem();
        imem[0] = enc_i(6'b001101, 5'd0, 5'd1, 16'hF0F0);
        imem[1] = enc_i(6'b001101, 5'd0, 5'd2, 16'h8001);
        imem[2] = enc_i(6'b001101, 5'd1, 5'd3, 16'h0F0F);
        imem[3] = enc_i(6'b101011, 5'd0, 5'd1, 16'h0000);
        imem[4] = enc_i(6'b101011, 5'd0, 5'd2, 16'h0004);
        imem[5] = enc_i(6'b101011, 5'd0, 5'd3, 16'h0008);
        do_reset();
        run(60);
        chk("R3 ori basic", dmem[0], 32'h0000_F0F0);
        chk("R3 ori zero-extended", dmem[1], 32'h0000_8001);
        chk("R3 ori with register source", dmem[2], 32'h0000_FFFF);
        chk("R5 three stores", 32'(wr_cnt), 32'd3);
        chk("R6 halt pc", pc_dbg, 32'd24);
    endtask

    // R2: register-register add, subtract and default-to-add.
    task automatic t_rtype();
        clear_mem();
        imem[0] = enc_i(6'b001101, 5'd0, 5'd1, 16'd10);
        imem[1] = enc_i(6'b001101, 5'd0, 5'd2, 16'd3);
        imem[2] = enc_r(5'd1, 5'd2, 5'd3, 6'b100001);
        imem[3] = enc_r(5'd1, 5'd2, 5'd4, 6'b100011);
        imem[4] = enc_r(5'd2, 5'd1, 5'd5, 6'b100011);
        imem[5] = enc_r(5'd1, 5'd2, 5'd6, 6'b000000);
        imem[6] = enc_i(6'b101011, 5'd0, 5'd3, 16'h0000);
        imem[7] = enc_i(6'b101011, 5'd0, 5'd4, 16'h0004);
        imem[8] = enc_i(6'b101011, 5'd0, 5'd5, 16'h0008);
        imem[9] = enc_i(6'b101011, 5'd0, 5'd6, 16'h000C);
        do_reset();
        run(90);
        chk("R2 add", dmem[0], 32'd13);
        chk("R2 sub", dmem[1], 32'd7);
        chk("R2 sub negative", dmem[2], 32'hFFFF_FFF9);
        chk("R2 unknown function adds", dmem[3], 32'd13);
        chk("R2 halt pc", pc_dbg, 32'd40);
    endtask

    // R4 and R5: loads and stores with negative and positive offsets.
    task automatic t_load_store();
        clear_mem();
        dmem[5] = 32'hDEAD_BEEF;
        imem[0] = enc_i(6'b001101, 5'd0, 5'd1, 16'h0020);
        imem[1] = enc_i(6'b100011, 5'd1, 5'd2, 16'hFFF4);
        imem[2] = enc_i(6'b101011, 5'd1, 5'd2, 16'hFFFC);
        imem[3] = enc_i(6'b100011, 5'd0, 5'd3, 16'h0014);
        imem[4] = enc_i(6'b101011, 5'd0, 5'd3, 16'h0000);
        do_reset();
        run(60);
        chk("R5 store negative offset", dmem[7], 32'hDEAD_BEEF);
        chk("R4 load positive offset", dmem[0], 32'hDEAD_BEEF);
        chk("R5 untouched word", dmem[6], 32'hA5A5_0006);
        chk("R5 two stores", 32'(wr_cnt), 32'd2);
        chk("R4 halt pc", pc_dbg, 32'd20);
    endtask

    // R7: register 0 ignores writes from every write path.
    task automatic t_zero_reg();
        clear_mem();
        dmem[0] = 32'hFFFF_FFFF;
        imem[0] = enc_i(6'b001101, 5'd0, 5'd0, 16'h0055);
        imem[1] = enc_i(6'b001101, 5'd0, 5'd1, 16'h0003);
        imem[2] = enc_r(5'd1, 5'd1, 5'd0, 6'b100001);
        imem[3] = enc_i(6'b100011, 5'd0, 5'd0, 16'h0008);
        imem[4] = enc_i(6'b101011, 5'd0, 5'd0, 16'h0000);
        do_reset();
        run(60);
        chk("R7 r0 reads zero", dmem[0], 32'h0);
    endtask

    // R6: taken and fall-through branches.
    task automatic t_branch();
        clear_mem();
        dmem[0] = 32'h0000_1234;
        imem[0] = enc_i(6'b001101, 5'd0, 5'd1, 16'd7);
        imem[1] = enc_i(6'b001101, 5'd0, 5'd2, 16'd7);
        imem[2] = enc_i(6'b000100, 5'd1, 5'd2, 16'd2);
        imem[3] = enc_i(6'b001101, 5'd0, 5'd3, 16'd1);
        imem[4] = enc_i(6'b000100, 5'd1, 5'd0, 16'd5);
        imem[5] = enc_i(6'b101011, 5'd0, 5'd3, 16'h0000);
        do_reset();
        run(60);
        chk("R6 taken branch skipped a write", dmem[0], 32'h0);
        chk("R6 fall-through reached halt", pc_dbg, 32'd24);
    endtask

    // R9: an unknown opcode only advances PC.
    task automatic t_unknown();
        clear_mem();
        imem[0] = enc_i(6'b001101, 5'd0, 5'd1, 16'd5);
        imem[1] = enc_i(6'b111111, 5'd2, 5'd1, 16'h0000);
        imem[2] = enc_i(6'b101011, 5'd0, 5'd1, 16'h0000);
        do_reset();
        run(40);
        chk("R9 register unchanged", dmem[0], 32'd5);
        chk("R9 no extra memory write", 32'(wr_cnt), 32'd1);
        chk("R9 pc advanced", pc_dbg, 32'd12);
    endtask

    // R2-class timing: cycles from reset release until PC first moves.
    task automatic t_timing(input string req, input logic [31:0] ins,
                            input int exp_cyc, input logic [31:0] exp_pc);
        int cnt;
        clear_mem();
        imem[0] = ins;
        do_reset();
        cnt = 0;
        while (pc_dbg == 32'h0 && cnt < 20) begin
            @(posedge clk);
            #1;
            cnt++;
        end
        chk(req, 32'(cnt), 32'(exp_cyc));
        chk(req, pc_dbg, exp_pc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_ori();
        t_rtype();
        t_load_store();
        t_zero_reg();
        t_branch();
        t_unknown();
        t_timing("R2 cycles", enc_r(5'd1, 5'd2, 5'd3, 6'b100001), 4, 32'd4);
        t_timing("R3 cycles", enc_i(6'b001101, 5'd0, 5'd1, 16'h1), 4, 32'd4);
        t_timing("R4 cycles", enc_i(6'b100011, 5'd0, 5'd1, 16'h0), 5, 32'd4);
        t_timing("R5 cycles", enc_i(6'b101011, 5'd0, 5'd1, 16'h0), 4, 32'd4);
        t_timing("R6 cycles", enc_i(6'b000100, 5'd0, 5'd0, 16'd3), 3, 32'd12);
        t_timing("R9 cycles", enc_i(6'b111110, 5'd0, 5'd0, 16'h0), 2, 32'd4);
        t_timing("R8 fetch holds pc", enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF), 3, 32'hFFFF_FFFC);
        summary();
        $finish;
    end

endmodule